// File: doc/BRIEF.md
# Video Test Pattern Generator

The block produces a synthetic video stream on a streaming output with valid/ready flow control. Each beat carries a fixed number of pixels, set at compile time. The first beat of every frame or field is flagged on `m_tuser`, and the last beat of every line is flagged on `m_tlast`. Two kinds of picture are available. The first is vertical bars, in four variants. The second is a single constant colour taken from three component inputs. The picture can be sent as RGB, YCbCr 4:4:4, YCbCr 4:2:2 or monochrome.

All configuration is presented on plain inputs. The block captures it only at a frame or field boundary, so a host may change the inputs at any time without tearing the picture. A 4-bit interlace code selects one of three outputs: progressive frames, fields starting with F0, or fields starting with F1. In the interlaced cases each field carries half the frame height, and the field identity is shown on `m_tfield`.

Top module: `vpat_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `m_tvalid` is 0. From the second cycle after release, `m_tvalid` stays 1 until the next reset. Generation restarts at pixel 0 of line 0.
- R2: `m_tuser` is 1 exactly on the first beat (pixel 0, line 0) of each frame or field, and 0 on every other valid beat.
- R3: A line takes ceil(W/P) beats, where W is the width and P the pixels per beat. `m_tlast` is 1 only on the final beat of each line.
- R4: Interlace code bit 3 = 0 (values 0–7) gives progressive frames of H lines with `m_tfield` = 0. Values 8–11 give fields of max(H/2,1) lines, starting with F0 (`m_tfield` = 0) after reset. Values 12–15 give the same fields starting with F1. While interlaced, consecutive fields alternate. Switching from progressive to interlaced starts with the field given by code bit 2.
- R5: Colour bars (`cfg_pat` = 0, `cfg_bars` = 0) split the line into 8 bars, with pixel x in bar floor(8x/W). From left to right the bars are white, yellow, cyan, green, magenta, red, blue and black. In RGB, each component is either full scale M = 2^B−1 or 0. In YCbCr, the values are Y = (77r+150g+29b)·M/256, Cb = (256·C + (128b−43r−85g)·M)/256 and Cr = (256·C + (128r−107g−21b)·M)/256. Here r, g and b are 0 or 1, C = 2^(B−1), and every division truncates.
- R6: Greyscale bars (`cfg_bars` = 1) give bar k the level M·(7−k)/7 (truncated). In RGB all three components carry this level. In YCbCr it is Y, with both chroma samples equal to C.
- R7: Black-and-white bars (`cfg_bars` = 2) give even bars level M and odd bars level 0. The components are formed as in R6.
- R8: Mixed bars (`cfg_bars` = 3) show colour bars on lines y < L/2 of the frame or field, where L is its line count, and greyscale bars on the remaining lines.
- R9: Constant colour (`cfg_pat` = 1) sets every pixel to `cfg_k0` (R or Cr), `cfg_k1` (G or Y) and `cfg_k2` (B or Cb).
- R10: Each pixel occupies 3·B bits of `m_tdata`, with pixel 0 in the least significant slot. Within a pixel the slots are A in [B−1:0], then B, then C. For `cfg_fmt` = 0 (RGB) and 1 (YCbCr 4:4:4): A = G/Y, B = B/Cb, C = R/Cr. For `cfg_fmt` = 2 (4:2:2): A = Y, B = Cb on even x and Cr on odd x, C = 0.
- R11: With `cfg_fmt` = 3 (monochrome), slot A holds the Y value and slots B and C are 0.
- R12: Pixel slots beyond the line width on the final beat of a line are all zero.
- R13: While `m_tvalid` is 1 and `m_tready` is 0, every output holds its value and generation pauses. No pixel is lost or repeated.
- R14: Configuration is captured in the first cycle after reset, and on the edge that transfers the last beat of a frame or field. Changes at any other time do not affect the current frame or field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | DIM_W | Pixels per line (1–16384) |
| cfg_height | input | DIM_W | Lines per frame (1–16384) |
| cfg_ilace | input | 4 | Interlace code |
| cfg_fmt | input | 2 | 0 RGB, 1 YCbCr 4:4:4, 2 YCbCr 4:2:2, 3 mono |
| cfg_pat | input | 1 | 0 bars, 1 constant colour |
| cfg_bars | input | 2 | 0 colour, 1 grey, 2 black-and-white, 3 mixed |
| cfg_k0 | input | BPS | Constant R / Cr |
| cfg_k1 | input | BPS | Constant G / Y |
| cfg_k2 | input | BPS | Constant B / Cb |
| m_tready | input | 1 | Downstream ready |
| m_tvalid | output | 1 | Beat valid |
| m_tdata | output | PPB·3·BPS | Pixel data |
| m_tuser | output | 1 | Start of frame or field |
| m_tlast | output | 1 | End of line |
| m_tfield | output | 1 | Field identity (0 = F0) |

## Verification
The hardest cycle is the last beat of a frame or field. In that cycle the line wraps, the field toggles and new configuration is captured, and backpressure may stall the beat at the same moment. The bench changes the configuration while applying random backpressure, so pending changes often sit on a stalled final beat. A behavioural model captures the configuration on the same transfer edge. On every cycle it checks that the next beat carries `m_tuser`, the new field identity and the new picture, and that the stalled beat itself stayed unchanged.

// File: rtl/vpat_pkg.sv
package vpat_pkg;

   typedef enum logic [1:0] {
      FMT_RGB    = 2'd0,
      FMT_YCC444 = 2'd1,
      FMT_YCC422 = 2'd2,
      FMT_MONO   = 2'd3
   } fmt_e;

   typedef enum logic [1:0] {
      BARS_COLOUR = 2'd0,
      BARS_GREY   = 2'd1,
      BARS_BW     = 2'd2,
      BARS_MIXED  = 2'd3
   } bars_e;

   // {r,g,b} presence flags for bar index 0..7 (white .. black)
   function automatic logic [2:0] bar_rgb(input logic [2:0] bar);
      return {~bar[1], ~bar[2], ~bar[0]};
   endfunction

   function automatic int ycc_y(input int r, input int g, input int b, input int maxv);
      return ((77 * r + 150 * g + 29 * b) * maxv) / 256;
   endfunction

   function automatic int ycc_cb(input int r, input int g, input int b,
                                 input int maxv, input int mid);
      return (256 * mid + (128 * b - 43 * r - 85 * g) * maxv) / 256;
   endfunction

   function automatic int ycc_cr(input int r, input int g, input int b,
                                 input int maxv, input int mid);
      return (256 * mid + (128 * r - 107 * g - 21 * b) * maxv) / 256;
   endfunction

   function automatic int grey_level(input int bar, input int maxv);
      return (maxv * (7 - bar)) / 7;
   endfunction

endpackage

// File: rtl/vpat_scan.sv
module vpat_scan #(
   parameter int PPB   = 2,
   parameter int DIM_W = 15,
   parameter int BPS   = 8,
   localparam int XW   = DIM_W + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ready,
   input  logic [DIM_W-1:0] cfg_width,
   input  logic [DIM_W-1:0] cfg_height,
   input  logic [3:0]       cfg_ilace,
   input  logic [1:0]       cfg_fmt,
   input  logic             cfg_pat,
   input  logic [1:0]       cfg_bars,
   input  logic [BPS-1:0]   cfg_k0,
   input  logic [BPS-1:0]   cfg_k1,
   input  logic [BPS-1:0]   cfg_k2,
   output logic             run,
   output logic [XW-1:0]    x_base,
   output logic [DIM_W-1:0] y_line,
   output logic             field,
   output logic             eol,
   output logic             top_half,
   output logic [DIM_W-1:0] wid_q,
   output logic [1:0]       fmt_q,
   output logic             pat_q,
   output logic [1:0]       bars_q,
   output logic [BPS-1:0]   k0_q,
   output logic [BPS-1:0]   k1_q,
   output logic [BPS-1:0]   k2_q
);

   logic [DIM_W-1:0] lines_q;
   logic             il_q;
   logic [DIM_W-1:0] half_h;
   logic [DIM_W-1:0] lines_nx;
   logic             eof;
   logic             load;
   logic             next_field;

   assign half_h     = cfg_height >> 1;
   assign lines_nx   = cfg_ilace[3] ? ((half_h == '0) ? DIM_W'(1) : half_h) : cfg_height;
   assign eol        = (x_base + XW'(PPB)) >= {1'b0, wid_q};
   assign eof        = eol && (y_line == (lines_q - DIM_W'(1)));
   assign top_half   = y_line < (lines_q >> 1);
   assign load       = !run || (ready && eof);
   assign next_field = !cfg_ilace[3] ? 1'b0 : (il_q ? ~field : cfg_ilace[2]);

   always_ff @(posedge clk) begin
      if (rst) begin
         run    <= 1'b0;
         x_base <= '0;
         y_line <= '0;
      end else begin
         run <= 1'b1;
         if (run && ready) begin
            if (eol) begin
               x_base <= '0;
               y_line <= eof ? '0 : y_line + DIM_W'(1);
            end else begin
               x_base <= x_base + XW'(PPB);
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wid_q   <= '0;
         lines_q <= DIM_W'(1);
         il_q    <= 1'b0;
         field   <= 1'b0;
         fmt_q   <= '0;
         pat_q   <= 1'b0;
         bars_q  <= '0;
         k0_q    <= '0;
         k1_q    <= '0;
         k2_q    <= '0;
      end else if (load) begin
         wid_q   <= cfg_width;
         lines_q <= lines_nx;
         il_q    <= cfg_ilace[3];
         field   <= run ? next_field : (cfg_ilace[3] & cfg_ilace[2]);
         fmt_q   <= cfg_fmt;
         pat_q   <= cfg_pat;
         bars_q  <= cfg_bars;
         k0_q    <= cfg_k0;
         k1_q    <= cfg_k1;
         k2_q    <= cfg_k2;
      end
   end

   AST_RUN_PERSIST: assert property (@(posedge clk) disable iff (rst)
      run |=> run); // R1

   AST_LINE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      run |-> (y_line < lines_q)); // R4

   AST_WRAP_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
      (run && ready && eol) |=> (x_base == '0)); // R3

endmodule

// File: rtl/vpat_pixel.sv
module vpat_pixel
   import vpat_pkg::*;
#(
   parameter int BPS = 8,
   parameter int XW  = 16
) (
   input  logic [XW-1:0]    px_x,
   input  logic [XW-1:0]    width,
   input  logic             top_half,
   input  logic [1:0]       fmt,
   input  logic             pat_const,
   input  logic [1:0]       bars,
   input  logic [BPS-1:0]   k0,
   input  logic [BPS-1:0]   k1,
   input  logic [BPS-1:0]   k2,
   output logic [3*BPS-1:0] px_data
);

   localparam int MAXV = (2 ** BPS) - 1;
   localparam int MIDV = 2 ** (BPS - 1);
   localparam int TW   = XW + 4;

   logic [2:0]     bar;
   logic [2:0]     rgb;
   logic           use_col;
   int             lvl;
   bars_e          mode;
   fmt_e           fmt_v;
   logic [BPS-1:0] p0, p1, p2;

   // bar index = number of thresholds k*W (k=1..7) not above 8x
   always_comb begin
      bar = 3'd0;
      for (int k = 1; k < 8; k++) begin
         if (TW'({px_x, 3'b000}) >= TW'(k) * TW'(width)) bar = bar + 3'd1;
      end
   end

   always_comb begin
      mode    = bars_e'(bars);
      fmt_v   = fmt_e'(fmt);
      rgb     = bar_rgb(bar);
      use_col = (mode == BARS_COLOUR) || ((mode == BARS_MIXED) && top_half);
      lvl     = (mode == BARS_BW) ? (bar[0] ? 0 : MAXV) : grey_level(int'(bar), MAXV);
      if (pat_const) begin
         p0 = k0;
         p1 = k1;
         p2 = k2;
      end else if (use_col) begin
         if (fmt_v == FMT_RGB) begin
            p0 = rgb[2] ? BPS'(MAXV) : '0;
            p1 = rgb[1] ? BPS'(MAXV) : '0;
            p2 = rgb[0] ? BPS'(MAXV) : '0;
         end else begin
            p1 = BPS'(ycc_y(int'(rgb[2]), int'(rgb[1]), int'(rgb[0]), MAXV));
            p2 = BPS'(ycc_cb(int'(rgb[2]), int'(rgb[1]), int'(rgb[0]), MAXV, MIDV));
            p0 = BPS'(ycc_cr(int'(rgb[2]), int'(rgb[1]), int'(rgb[0]), MAXV, MIDV));
         end
      end else begin
         p1 = BPS'(lvl);
         p0 = (fmt_v == FMT_RGB) ? BPS'(lvl) : BPS'(MIDV);
         p2 = (fmt_v == FMT_RGB) ? BPS'(lvl) : BPS'(MIDV);
      end
   end

   always_comb begin
      if (px_x >= width) begin
         px_data = '0;
      end else begin
         case (fmt_v)
            FMT_YCC422: px_data = {BPS'(0), (px_x[0] ? p0 : p2), p1};
            FMT_MONO:   px_data = {BPS'(0), BPS'(0), p1};
            default:    px_data = {p0, p2, p1};
         endcase
      end
   end

endmodule

// File: rtl/vpat_gen.sv
module vpat_gen #(
   parameter int PPB   = 2,
   parameter int BPS   = 8,
   parameter int DIM_W = 15,
   localparam int XW   = DIM_W + 1,
   localparam int PXW  = 3 * BPS
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [DIM_W-1:0]   cfg_width,
   input  logic [DIM_W-1:0]   cfg_height,
   input  logic [3:0]         cfg_ilace,
   input  logic [1:0]         cfg_fmt,
   input  logic               cfg_pat,
   input  logic [1:0]         cfg_bars,
   input  logic [BPS-1:0]     cfg_k0,
   input  logic [BPS-1:0]     cfg_k1,
   input  logic [BPS-1:0]     cfg_k2,
   input  logic               m_tready,
   output logic               m_tvalid,
   output logic [PPB*PXW-1:0] m_tdata,
   output logic               m_tuser,
   output logic               m_tlast,
   output logic               m_tfield
);

   if (PPB < 1 || PPB > 8) begin : g_bad_ppb
      $error("vpat_gen: PPB must be 1..8");
   end
   if (BPS < 8 || BPS > 16) begin : g_bad_bps
      $error("vpat_gen: BPS must be 8..16");
   end
   if (DIM_W < 2 || DIM_W > 15) begin : g_bad_dim
      $error("vpat_gen: DIM_W must be 2..15");
   end

   logic             run, field, eol, top_half, pat_q;
   logic [XW-1:0]    x_base;
   logic [DIM_W-1:0] y_line, wid_q;
   logic [1:0]       fmt_q, bars_q;
   logic [BPS-1:0]   k0_q, k1_q, k2_q;

   vpat_scan #(.PPB(PPB), .DIM_W(DIM_W), .BPS(BPS)) u_scan (
      .clk(clk), .rst(rst), .ready(m_tready),
      .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_ilace(cfg_ilace),
      .cfg_fmt(cfg_fmt), .cfg_pat(cfg_pat), .cfg_bars(cfg_bars),
      .cfg_k0(cfg_k0), .cfg_k1(cfg_k1), .cfg_k2(cfg_k2),
      .run(run), .x_base(x_base), .y_line(y_line), .field(field), .eol(eol),
      .top_half(top_half), .wid_q(wid_q), .fmt_q(fmt_q), .pat_q(pat_q),
      .bars_q(bars_q), .k0_q(k0_q), .k1_q(k1_q), .k2_q(k2_q)
   );

   for (genvar gi = 0; gi < PPB; gi++) begin : g_lane
      vpat_pixel #(.BPS(BPS), .XW(XW)) u_pixel (
         .px_x(x_base + XW'(gi)), .width({1'b0, wid_q}), .top_half(top_half),
         .fmt(fmt_q), .pat_const(pat_q), .bars(bars_q),
         .k0(k0_q), .k1(k1_q), .k2(k2_q),
         .px_data(m_tdata[gi*PXW +: PXW])
      );
   end

   assign m_tvalid = run;
   assign m_tuser  = run && (x_base == '0) && (y_line == '0);
   assign m_tlast  = run && eol;
   assign m_tfield = field;

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
      (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tuser)
                                   && $stable(m_tlast) && $stable(m_tfield))); // R13

   AST_FIELD_STABLE: assert property (@(posedge clk) disable iff (rst)
      (m_tvalid && !m_tuser) |-> $stable(m_tfield)); // R4

endmodule

// File: tb/vpat_gen_tb.sv
module vpat_gen_tb;

   localparam int PPB  = 3;
   localparam int BPS  = 8;
   localparam int DW   = 15;
   localparam int PXW  = 3 * BPS;
   localparam int MAXV = 255;
   localparam int MIDV = 128;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic               rst;
   logic [DW-1:0]      cfg_width, cfg_height;
   logic [3:0]         cfg_ilace;
   logic [1:0]         cfg_fmt, cfg_bars;
   logic               cfg_pat;
   logic [BPS-1:0]     cfg_k0, cfg_k1, cfg_k2;
   logic               m_tready;
   logic               m_tvalid, m_tuser, m_tlast, m_tfield;
   logic [PPB*PXW-1:0] m_tdata;

   vpat_gen #(.PPB(PPB), .BPS(BPS), .DIM_W(DW)) u_dut (
      .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_height(cfg_height),
      .cfg_ilace(cfg_ilace), .cfg_fmt(cfg_fmt), .cfg_pat(cfg_pat), .cfg_bars(cfg_bars),
      .cfg_k0(cfg_k0), .cfg_k1(cfg_k1), .cfg_k2(cfg_k2), .m_tready(m_tready),
      .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tlast(m_tlast),
      .m_tfield(m_tfield)
   );

   int errors = 0;
   int checks = 0;
   bit done = 0;
   bit rnd_ready = 0;

   // behavioural model state
   bit m_run, m_field, m_il, stalled;
   int m_x, m_y;
   int L_w, L_lines, L_fmt, L_pat, L_bars, L_k0, L_k1, L_k2;
   logic [PPB*PXW-1:0] prev_data;
   bit prev_user, prev_last, prev_field;

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic load_cfg();
      int h;
      h = int'(cfg_height);
      L_w     = int'(cfg_width);
      L_lines = cfg_ilace[3] ? ((h / 2 < 1) ? 1 : h / 2) : h;
      L_fmt   = int'(cfg_fmt);
      L_pat   = int'(cfg_pat);
      L_bars  = int'(cfg_bars);
      L_k0    = int'(cfg_k0);
      L_k1    = int'(cfg_k1);
      L_k2    = int'(cfg_k2);
   endtask

   function automatic bit cfg_pending();
      int h, lines;
      h = int'(cfg_height);
      lines = cfg_ilace[3] ? ((h / 2 < 1) ? 1 : h / 2) : h;
      return (L_w != int'(cfg_width)) || (L_lines != lines) || (L_fmt != int'(cfg_fmt)) ||
             (L_pat != int'(cfg_pat)) || (L_bars != int'(cfg_bars)) ||
             (L_k0 != int'(cfg_k0)) || (L_k1 != int'(cfg_k1)) || (L_k2 != int'(cfg_k2));
   endfunction

   task automatic exp_px(input int i, output longint v, output string tag);
      int px, bar, r, g, b, lvl, p0, p1, p2;
      bit colour;
      px = m_x + i;
      if (px >= L_w) begin
         v = 0;
         tag = "R12";
         return;
      end
      bar = (8 * px) / L_w;
      case (bar)
         0: begin r = 1; g = 1; b = 1; end
         1: begin r = 1; g = 1; b = 0; end
         2: begin r = 0; g = 1; b = 1; end
         3: begin r = 0; g = 1; b = 0; end
         4: begin r = 1; g = 0; b = 1; end
         5: begin r = 1; g = 0; b = 0; end
         6: begin r = 0; g = 0; b = 1; end
         default: begin r = 0; g = 0; b = 0; end
      endcase
      colour = 0;
      if (L_pat == 1) begin
         p0 = L_k0; p1 = L_k1; p2 = L_k2;
         tag = "R9";
      end else begin
         case (L_bars)
            0: begin colour = 1; tag = "R5"; end
            1: tag = "R6";
            2: tag = "R7";
            default: begin colour = (m_y < L_lines / 2); tag = "R8"; end
         endcase
         if (colour) begin
            if (L_fmt == 0) begin
               p0 = r * MAXV; p1 = g * MAXV; p2 = b * MAXV;
            end else begin
               p1 = ((77 * r + 150 * g + 29 * b) * MAXV) / 256;
               p2 = (256 * MIDV + (128 * b - 43 * r - 85 * g) * MAXV) / 256;
               p0 = (256 * MIDV + (128 * r - 107 * g - 21 * b) * MAXV) / 256;
            end
         end else begin
            if (L_bars == 2) lvl = (bar % 2 == 0) ? MAXV : 0;
            else lvl = (MAXV * (7 - bar)) / 7;
            p1 = lvl;
            p0 = (L_fmt == 0) ? lvl : MIDV;
            p2 = (L_fmt == 0) ? lvl : MIDV;
         end
      end
      case (L_fmt)
         2: begin v = longint'((px % 2 == 1) ? p0 : p2) * 256 + p1; tag = "R10"; end
         3: begin v = p1; tag = "R11"; end
         default: v = longint'(p0) * 65536 + longint'(p2) * 256 + p1;
      endcase
      if (cfg_pending()) tag = "R14";
   endtask

   task automatic compare();
      longint ev;
      string tg;
      chk("R1", "tvalid", longint'(m_tvalid), longint'(m_run));
      if (m_run) begin
         chk("R2", "tuser", longint'(m_tuser), longint'(m_x == 0 && m_y == 0));
         chk("R3", "tlast", longint'(m_tlast), longint'(m_x + PPB >= L_w));
         chk("R4", "tfield", longint'(m_tfield), longint'(m_field));
         for (int i = 0; i < PPB; i++) begin
            exp_px(i, ev, tg);
            chk(tg, $sformatf("pixel %0d of beat x=%0d y=%0d", i, m_x, m_y),
                longint'(m_tdata[i*PXW +: PXW]), ev);
         end
      end
      if (stalled) begin
         chk("R13", "held beat", longint'(m_tdata == prev_data && m_tuser == prev_user &&
             m_tlast == prev_last && m_tfield == prev_field && m_tvalid), 1);
      end
      prev_data  = m_tdata;
      prev_user  = m_tuser;
      prev_last  = m_tlast;
      prev_field = m_tfield;
   endtask

   // drive for next edge, advance model across it, then compare after it
   task automatic tick();
      bit nf;
      if (rnd_ready) m_tready = ($urandom_range(0, 3) != 0);
      stalled = m_run && !m_tready && !rst;
      if (rst) begin
         m_run = 0; m_x = 0; m_y = 0;
      end else if (!m_run) begin
         load_cfg();
         m_run = 1;
         m_field = cfg_ilace[3] && cfg_ilace[2];
         m_il = cfg_ilace[3];
      end else if (m_tready) begin
         if (m_x + PPB >= L_w) begin
            m_x = 0;
            if (m_y == L_lines - 1) begin
               m_y = 0;
               nf = !cfg_ilace[3] ? 1'b0 : (m_il ? !m_field : cfg_ilace[2]);
               m_il = cfg_ilace[3];
               m_field = nf;
               load_cfg();
            end else begin
               m_y++;
            end
         end else begin
            m_x += PPB;
         end
      end
      @(negedge clk);
      compare();
   endtask

   task automatic run_cycles(input int n);
      repeat (n) tick();
   endtask

   task automatic setcfg(input int w, input int h, input int il, input int fmt,
                         input int pat, input int bars, input int k0, input int k1, input int k2);
      cfg_width  = DW'(w);
      cfg_height = DW'(h);
      cfg_ilace  = 4'(il);
      cfg_fmt    = 2'(fmt);
      cfg_pat    = 1'(pat);
      cfg_bars   = 2'(bars);
      cfg_k0     = BPS'(k0);
      cfg_k1     = BPS'(k1);
      cfg_k2     = BPS'(k2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R1 watchdog expired actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst = 1'b1;
      m_tready = 1'b1;
      m_run = 0; m_x = 0; m_y = 0; m_field = 0; m_il = 0; stalled = 0;
      L_w = 1; L_lines = 1; L_fmt = 0; L_pat = 0; L_bars = 0; L_k0 = 0; L_k1 = 0; L_k2 = 0;
      setcfg(16, 4, 0, 0, 0, 0, 0, 0, 0);
      @(negedge clk);
      run_cycles(3);                                 // R1 reset state
      rst = 1'b0;
      run_cycles(60);                                // R5 RGB colour bars
      setcfg(16, 4, 0, 1, 0, 0, 0, 0, 0);  run_cycles(60);   // R5 YCbCr
      setcfg(13, 3, 1, 0, 0, 1, 0, 0, 0);  run_cycles(60);   // R6, R12 padding
      setcfg(8, 2, 5, 0, 0, 2, 0, 0, 0);   run_cycles(40);   // R7
      setcfg(10, 6, 9, 1, 0, 3, 0, 0, 0);  run_cycles(80);   // R8, R4 F0 first
      rnd_ready = 1;
      setcfg(12, 4, 14, 2, 0, 0, 0, 0, 0); run_cycles(150);  // R10, R13, R4
      setcfg(12, 5, 8, 3, 0, 1, 0, 0, 0);  run_cycles(150);  // R11
      setcfg(7, 3, 0, 0, 1, 0, 10, 20, 30); run_cycles(120); // R9
      setcfg(14, 2, 3, 2, 1, 0, 40, 50, 60); run_cycles(120); // R9, R10
      rnd_ready = 0; m_tready = 1'b1;
      setcfg(1, 1, 0, 0, 0, 0, 0, 0, 0);   run_cycles(20);   // R3 min size
      setcfg(9, 1, 12, 1, 0, 3, 0, 0, 0);  run_cycles(40);   // R4 H=1 interlaced
      rnd_ready = 1;
      setcfg(20, 3, 0, 0, 0, 3, 0, 0, 0);  run_cycles(200);  // R8 with stalls
      for (int n = 0; n < 6; n++) begin                      // R14 mid-frame changes
         setcfg(5 + n, 2 + n % 3, (n % 2) * 12, n % 4, n % 2, 3 - n % 4, n, 2 * n, 3 * n);
         run_cycles(37);
      end
      rnd_ready = 0; m_tready = 1'b1;
      setcfg(16, 4, 12, 0, 0, 0, 0, 0, 0);
      rst = 1'b1; run_cycles(2);                     // R1 reset mid-run, F1 first
      rst = 1'b0; run_cycles(80);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule